// File: doc/BRIEF.md
# Four-Rail Power-Good Sequencer

This block brings up four downstream supplies in a fixed order. It watches a set of supervisor comparator outputs for the input supply and a power-on-reset done signal. Once the supply sits inside its allowed window, it waits a programmable startup interval and then turns on power-good enable A. Enables B, C and D follow one at a time, each after its own programmable delay. All timing is counted in ticks from a divided timebase, so the clock rate does not set the delays.

Each inter-stage delay models a triangular oscillator followed by an 8-bit period counter. One oscillator period is a charge phase plus a discharge phase, each lasting as many ticks as the stage's delay code. The delay runs for 255 such periods. Any supervisor fault turns every enable off at once and restarts the whole sequence from the startup interval when the supply recovers. A parameter selects whether the enables are active-high or active-low. A separate ready output, always active-high, lets one sequencer gate a further one in a chain.

Top module: `pgood_sequencer`

## Requirements
- R1: The enables come on strictly in the order A, B, C, D. The set of active enables is always one of: none, A, A+B, A+B+C, or all four.
- R2: While `rst` is high, or while `por_done` is low, all four enables are inactive and `chain_ready` is 0.
- R3: Once the supply window becomes valid, A comes on at the `ramp_len`-th tick the sequencer counts. A `ramp_len` of zero counts as one tick.
- R4: B, C and D each come on after their own delay code (`dly_b`, `dly_c`, `dly_d`), measured from the moment the previous enable came on. No two enables come on in the same cycle.
- R5: Each inter-stage delay is exactly 2 x 255 x code ticks: 255 oscillator periods, each a charge phase plus a discharge phase of `code` ticks. Codes 1 to 255 therefore give a 1:255 range, which covers a 5 ms to 200 ms span for a suitable tick rate.
- R6: An undervoltage or overvoltage trip, or a drop of `por_done`, turns all enables off in the first cycle after the clock edge that registers it. No tick is needed for this.
- R7: When the window becomes valid again after a fault, a fresh sequence starts from the startup interval. A again comes on `ramp_len` ticks later, and the stage delays follow as in R4.
- R8: The overvoltage fault sets when `ov_above_hi` is 1. It clears only when `ov_below_lo` is 1. While both inputs are 0, the fault holds its state.
- R9: The undervoltage fault sets when `uv_below_lo` is 1. It clears only when `uv_above_hi` is 1. While both inputs are 0, the fault holds its state. The fault is set out of reset.
- R10: With `ACTIVE_HIGH`=1, an active enable reads 1 on `pg_o`. With `ACTIVE_HIGH`=0, it reads 0. Bit i of `pg_o` is rail A+i, so bit 0 is A and bit 3 is D.
- R11: `chain_ready` is 1 exactly when all four enables are active, regardless of polarity.
- R12: A delay code of zero acts as code 1, so consecutive enables are always at least 510 ticks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| uv_above_hi | input | 1 | Undervoltage sense is above its upper threshold |
| uv_below_lo | input | 1 | Undervoltage sense is below its lower threshold |
| ov_above_hi | input | 1 | Overvoltage sense is above its upper threshold |
| ov_below_lo | input | 1 | Overvoltage sense is below its lower threshold |
| por_done | input | 1 | Internal supply power-on reset has completed |
| tick | input | 1 | One-cycle timebase pulse |
| ramp_len | input | RAMP_W (16) | Startup interval in ticks |
| dly_b | input | CODE_W (8) | Delay code from A to B |
| dly_c | input | CODE_W (8) | Delay code from B to C |
| dly_d | input | CODE_W (8) | Delay code from C to D |
| pg_o | output | 4 | Power-good enables, bit 0 = A, polarity set by ACTIVE_HIGH |
| chain_ready | output | 1 | All four enables active, for chaining |

## Verification
A supervisor input applied before clock edge k is registered at edge k. The enables go dark right after that edge, so the bench drives inputs on the falling edge and checks for the dark enables at the next falling edge. The bench drives the tick on every second cycle, so each stage delay is exactly 2 x 510 x code cycles between two rises. The bench compares these rise-to-rise gaps exactly. The startup interval depends on where the first counted tick falls relative to qualification. The bench therefore measures it from the falling edge where the window input changed and accepts a window of 2N to 2N+2 cycles, where N is the effective `ramp_len`.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

    localparam int RAILS = 4;

    typedef enum logic [2:0] {
        SEQ_HOLD   = 3'd0,
        SEQ_RAMP   = 3'd1,
        SEQ_WAIT_B = 3'd2,
        SEQ_WAIT_C = 3'd3,
        SEQ_WAIT_D = 3'd4,
        SEQ_ALL_ON = 3'd5
    } seq_state_t;

    typedef struct packed {
        logic uv_flt;
        logic ov_flt;
        logic por_ok;
    } window_t;

    // Thermometer of enables that a sequencer state has already reached.
    function automatic logic [RAILS-1:0] reached_mask(seq_state_t s);
        logic [RAILS-1:0] m;
        case (s)
            SEQ_WAIT_B: m = 4'b0001;
            SEQ_WAIT_C: m = 4'b0011;
            SEQ_WAIT_D: m = 4'b0111;
            SEQ_ALL_ON: m = 4'b1111;
            default:    m = 4'b0000;
        endcase
        return m;
    endfunction

    function automatic logic is_stage_wait(seq_state_t s);
        return (s == SEQ_WAIT_B) || (s == SEQ_WAIT_C) || (s == SEQ_WAIT_D);
    endfunction

endpackage

// File: rtl/pgs_window.sv
module pgs_window
    import pgs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    uv_above_hi,
    input  logic    uv_below_lo,
    input  logic    ov_above_hi,
    input  logic    ov_below_lo,
    input  logic    por_done,
    output window_t win,
    output logic    fault
);

    window_t win_q;

    // Trip inputs win over clear inputs if both are seen together.
    always_ff @(posedge clk) begin
        if (rst) begin
            win_q.uv_flt <= 1'b1;
            win_q.ov_flt <= 1'b0;
            win_q.por_ok <= 1'b0;
        end else begin
            if (uv_below_lo)      win_q.uv_flt <= 1'b1;
            else if (uv_above_hi) win_q.uv_flt <= 1'b0;

            if (ov_above_hi)      win_q.ov_flt <= 1'b1;
            else if (ov_below_lo) win_q.ov_flt <= 1'b0;

            win_q.por_ok <= por_done;
        end
    end

    assign win   = win_q;
    assign fault = win_q.uv_flt | win_q.ov_flt | ~win_q.por_ok;

endmodule

// File: rtl/pgs_ramp_timer.sv
module pgs_ramp_timer #(
    parameter int RAMP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              tick,
    input  logic [RAMP_W-1:0] limit,
    output logic              done
);

    logic [RAMP_W-1:0] cnt_q;
    logic [RAMP_W-1:0] last;

    assign last = (limit == '0) ? '0 : limit - RAMP_W'(1);
    assign done = run && tick && (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || !run || done) cnt_q <= '0;
        else if (tick)           cnt_q <= cnt_q + RAMP_W'(1);
    end

endmodule

// File: rtl/pgs_stage_timer.sv
module pgs_stage_timer #(
    parameter int CODE_W  = 8,
    parameter int PERIODS = 255
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              tick,
    input  logic [CODE_W-1:0] code,
    output logic              done
);

    localparam int PER_W = $clog2(PERIODS + 1);

    logic [CODE_W-1:0] phase_q;
    logic              discharge_q;
    logic [PER_W-1:0]  period_q;
    logic [CODE_W-1:0] phase_last;
    logic              phase_end;
    logic              period_end;

    // A zero code behaves as the shortest phase of one tick.
    assign phase_last = (code == '0) ? '0 : code - CODE_W'(1);
    assign phase_end  = run && tick && (phase_q == phase_last);
    assign period_end = phase_end && discharge_q;
    assign done       = period_end && (period_q == PER_W'(PERIODS - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || done) begin
            phase_q     <= '0;
            discharge_q <= 1'b0;
            period_q    <= '0;
        end else if (tick) begin
            if (phase_end) begin
                phase_q     <= '0;
                discharge_q <= ~discharge_q;
                if (period_end) period_q <= period_q + PER_W'(1);
            end else begin
                phase_q <= phase_q + CODE_W'(1);
            end
        end
    end

endmodule

// File: rtl/pgs_flag_drive.sv
module pgs_flag_drive
    import pgs_pkg::*;
#(
    parameter bit ACTIVE_HIGH = 1'b1
) (
    input  seq_state_t       state,
    input  logic             fault,
    output logic [RAILS-1:0] pg_o,
    output logic             all_on
);

    logic [RAILS-1:0] active;

    assign active = reached_mask(state) & {RAILS{~fault}};
    assign all_on = &active;

    for (genvar g = 0; g < RAILS; g++) begin : g_rail
        if (ACTIVE_HIGH) begin : g_hi
            assign pg_o[g] = active[g];
        end else begin : g_lo
            assign pg_o[g] = ~active[g];
        end
    end

endmodule

// File: rtl/pgood_sequencer.sv
module pgood_sequencer
    import pgs_pkg::*;
#(
    parameter bit ACTIVE_HIGH = 1'b1,
    parameter int RAMP_W      = 16,
    parameter int CODE_W      = 8,
    parameter int PERIODS     = 255
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              uv_above_hi,
    input  logic              uv_below_lo,
    input  logic              ov_above_hi,
    input  logic              ov_below_lo,
    input  logic              por_done,
    input  logic              tick,
    input  logic [RAMP_W-1:0] ramp_len,
    input  logic [CODE_W-1:0] dly_b,
    input  logic [CODE_W-1:0] dly_c,
    input  logic [CODE_W-1:0] dly_d,
    output logic [3:0]        pg_o,
    output logic              chain_ready
);

    window_t           win;
    logic              fault_q;
    seq_state_t        state_q;
    seq_state_t        state_d;
    logic              ramp_run;
    logic              ramp_done;
    logic              stage_run;
    logic              stage_done;
    logic [CODE_W-1:0] stage_code;

    pgs_window u_window (
        .clk         (clk),
        .rst         (rst),
        .uv_above_hi (uv_above_hi),
        .uv_below_lo (uv_below_lo),
        .ov_above_hi (ov_above_hi),
        .ov_below_lo (ov_below_lo),
        .por_done    (por_done),
        .win         (win),
        .fault       (fault_q)
    );

    assign ramp_run  = (state_q == SEQ_RAMP) && !fault_q;
    assign stage_run = is_stage_wait(state_q) && !fault_q;

    always_comb begin
        case (state_q)
            SEQ_WAIT_C: stage_code = dly_c;
            SEQ_WAIT_D: stage_code = dly_d;
            default:    stage_code = dly_b;
        endcase
    end

    pgs_ramp_timer #(.RAMP_W(RAMP_W)) u_ramp (
        .clk   (clk),
        .rst   (rst),
        .run   (ramp_run),
        .tick  (tick),
        .limit (ramp_len),
        .done  (ramp_done)
    );

    pgs_stage_timer #(.CODE_W(CODE_W), .PERIODS(PERIODS)) u_stage (
        .clk   (clk),
        .rst   (rst),
        .run   (stage_run),
        .tick  (tick),
        .code  (stage_code),
        .done  (stage_done)
    );

    // A fault outranks every timing step in the same cycle.
    always_comb begin
        state_d = state_q;
        if (fault_q) begin
            state_d = SEQ_HOLD;
        end else begin
            case (state_q)
                SEQ_HOLD:   state_d = SEQ_RAMP;
                SEQ_RAMP:   if (ramp_done)  state_d = SEQ_WAIT_B;
                SEQ_WAIT_B: if (stage_done) state_d = SEQ_WAIT_C;
                SEQ_WAIT_C: if (stage_done) state_d = SEQ_WAIT_D;
                SEQ_WAIT_D: if (stage_done) state_d = SEQ_ALL_ON;
                SEQ_ALL_ON: state_d = SEQ_ALL_ON;
                default:    state_d = SEQ_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEQ_HOLD;
        else     state_q <= state_d;
    end

    pgs_flag_drive #(.ACTIVE_HIGH(ACTIVE_HIGH)) u_drive (
        .state  (state_q),
        .fault  (fault_q),
        .pg_o   (pg_o),
        .all_on (chain_ready)
    );

endmodule

// File: rtl/pgood_sequencer_chk.sv
module pgood_sequencer_chk #(
    parameter bit ACTIVE_HIGH = 1'b1
) (
    input logic       clk,
    input logic       rst,
    input logic [3:0] pg_o,
    input logic       chain_ready,
    input logic       fault_q,
    input logic       ov_flt,
    input logic       ov_below_lo,
    input logic       uv_flt,
    input logic       uv_above_hi
);

    logic [3:0] act;
    assign act = ACTIVE_HIGH ? pg_o : ~pg_o;

    AST_THERMO_ORDER: assert property (@(posedge clk) disable iff (rst)
        (act == 4'h0) || (act == 4'h1) || (act == 4'h3) || (act == 4'h7) || (act == 4'hF)); // R1

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
        $countones(act) <= $countones($past(act)) + 1); // R4

    AST_FAULT_DARK: assert property (@(posedge clk) disable iff (rst)
        fault_q |-> (act == 4'h0)); // R6

    AST_RESTART_DARK: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_q) |-> (act == 4'h0)); // R7

    AST_OV_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ov_flt && !ov_below_lo) |=> ov_flt); // R8

    AST_UV_HOLD: assert property (@(posedge clk) disable iff (rst)
        (uv_flt && !uv_above_hi) |=> uv_flt); // R9

    AST_CHAIN_FULL: assert property (@(posedge clk) disable iff (rst)
        chain_ready |-> (act == 4'hF)); // R11

endmodule

bind pgood_sequencer pgood_sequencer_chk #(.ACTIVE_HIGH(ACTIVE_HIGH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pg_o        (pg_o),
    .chain_ready (chain_ready),
    .fault_q     (fault_q),
    .ov_flt      (win.ov_flt),
    .ov_below_lo (ov_below_lo),
    .uv_flt      (win.uv_flt),
    .uv_above_hi (uv_above_hi)
);

// File: tb/pgood_sequencer_test.sv
module pgood_sequencer_test;

    localparam int TICK_DIV   = 2;
    localparam int STAGE_UNIT = 2 * 255 * TICK_DIV;   // cycles per code step

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        uv_above_hi = 1'b0;
    logic        uv_below_lo = 1'b0;
    logic        ov_above_hi = 1'b0;
    logic        ov_below_lo = 1'b0;
    logic        por_done = 1'b0;
    logic        tick = 1'b0;
    logic [15:0] ramp_len = 16'd20;
    logic [7:0]  dly_b = 8'd1;
    logic [7:0]  dly_c = 8'd2;
    logic [7:0]  dly_d = 8'd3;
    logic [3:0]  pg_hi;
    logic [3:0]  pg_lo;
    logic        rdy_hi;
    logic        rdy_lo;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int order_err = 0;
    int pol_err = 0;
    int rise [4];
    logic [3:0] prev_pg = 4'h0;

    always #5 clk = ~clk;

    pgood_sequencer #(.ACTIVE_HIGH(1'b1)) uut (
        .clk(clk), .rst(rst),
        .uv_above_hi(uv_above_hi), .uv_below_lo(uv_below_lo),
        .ov_above_hi(ov_above_hi), .ov_below_lo(ov_below_lo),
        .por_done(por_done), .tick(tick), .ramp_len(ramp_len),
        .dly_b(dly_b), .dly_c(dly_c), .dly_d(dly_d),
        .pg_o(pg_hi), .chain_ready(rdy_hi)
    );

    pgood_sequencer #(.ACTIVE_HIGH(1'b0)) uut_lo (
        .clk(clk), .rst(rst),
        .uv_above_hi(uv_above_hi), .uv_below_lo(uv_below_lo),
        .ov_above_hi(ov_above_hi), .ov_below_lo(ov_below_lo),
        .por_done(por_done), .tick(tick), .ramp_len(ramp_len),
        .dly_b(dly_b), .dly_c(dly_c), .dly_d(dly_d),
        .pg_o(pg_lo), .chain_ready(rdy_lo)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) tick <= ((cyc % TICK_DIV) == 0);

    always @(negedge clk) begin
        for (int i = 0; i < 4; i++)
            if (pg_hi[i] && !prev_pg[i]) rise[i] = cyc;
        if (!rst) begin
            if (!(pg_hi == 4'h0 || pg_hi == 4'h1 || pg_hi == 4'h3 ||
                  pg_hi == 4'h7 || pg_hi == 4'hF)) order_err++;
            if (pg_lo !== ~pg_hi || rdy_lo !== rdy_hi) pol_err++;
        end
        prev_pg = pg_hi;
    end

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_rises();
        for (int i = 0; i < 4; i++) rise[i] = -1;
    endtask

    task automatic wait_rise(int idx, int limit);
        for (int k = 0; k < limit && rise[idx] < 0; k++) @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic check_startup(int c0, int n_eff, string req);
        int d;
        d = rise[0] - c0;
        check(rise[0] >= 0 && d >= TICK_DIV * n_eff && d <= TICK_DIV * n_eff + 2,
              req, d, TICK_DIV * n_eff + 1);
    endtask

    // R2, R10, R11: reset and power-on-reset hold everything dark
    task automatic t_reset();
        idle(3);
        check(pg_hi == 4'h0, "R2 reset high-polarity", pg_hi, 0);
        check(pg_lo == 4'hF, "R10 reset low-polarity", pg_lo, 15);
        check(rdy_hi == 1'b0, "R11 reset ready", rdy_hi, 0);
        uv_above_hi = 1'b1;
        ov_below_lo = 1'b1;
        rst = 1'b0;
        idle(200);
        check(pg_hi == 4'h0, "R2 por not done", pg_hi, 0);
    endtask

    // R1, R3, R4, R5, R11: nominal full sequence
    task automatic t_nominal();
        int c0;
        clear_rises();
        por_done = 1'b1;
        c0 = cyc;
        wait_rise(3, 20000);
        check_startup(c0, 20, "R3 startup interval");
        check(rise[1] - rise[0] == STAGE_UNIT * 1, "R5 A to B code 1",
              rise[1] - rise[0], STAGE_UNIT);
        check(rise[2] - rise[1] == STAGE_UNIT * 2, "R4 B to C code 2",
              rise[2] - rise[1], STAGE_UNIT * 2);
        check(rise[3] - rise[2] == STAGE_UNIT * 3, "R4 C to D code 3",
              rise[3] - rise[2], STAGE_UNIT * 3);
        idle(2);
        check(rdy_hi == 1'b1 && pg_hi == 4'hF, "R11 ready when all on", rdy_hi, 1);
    endtask

    // R6, R7, R8: overvoltage trip with hysteresis, then restart
    task automatic t_ov_fault();
        int c0;
        ov_above_hi = 1'b1;
        ov_below_lo = 1'b0;
        @(negedge clk);
        check(pg_hi == 4'h0 && rdy_hi == 1'b0, "R6 ov trip immediate", pg_hi, 0);
        ov_above_hi = 1'b0;
        idle(3000);
        check(pg_hi == 4'h0, "R8 ov held between thresholds", pg_hi, 0);
        clear_rises();
        ov_below_lo = 1'b1;
        c0 = cyc;
        wait_rise(0, 500);
        check_startup(c0, 20, "R7 restart after ov");
    endtask

    // R6, R7, R9: undervoltage trip mid-sequence, hysteresis, restart
    task automatic t_uv_fault();
        int c0;
        wait_rise(1, 5000);
        idle(100);
        uv_above_hi = 1'b0;
        uv_below_lo = 1'b1;
        @(negedge clk);
        check(pg_hi == 4'h0, "R6 uv trip mid-sequence", pg_hi, 0);
        uv_below_lo = 1'b0;
        idle(3000);
        check(pg_hi == 4'h0, "R9 uv held between thresholds", pg_hi, 0);
        clear_rises();
        uv_above_hi = 1'b1;
        c0 = cyc;
        wait_rise(1, 5000);
        check_startup(c0, 20, "R7 restart after uv");
        check(rise[1] - rise[0] == STAGE_UNIT, "R7 stage delay after restart",
              rise[1] - rise[0], STAGE_UNIT);
    endtask

    // R12, R3: zero codes act as the minimum delay
    task automatic t_zero_codes();
        int c0;
        ov_above_hi = 1'b1;
        ov_below_lo = 1'b0;
        @(negedge clk);
        ov_above_hi = 1'b0;
        dly_b = 8'd0;
        dly_c = 8'd0;
        dly_d = 8'd0;
        ramp_len = 16'd0;
        idle(5);
        clear_rises();
        ov_below_lo = 1'b1;
        c0 = cyc;
        wait_rise(3, 10000);
        check_startup(c0, 1, "R3 zero startup length");
        check(rise[1] - rise[0] == STAGE_UNIT, "R12 zero code A to B",
              rise[1] - rise[0], STAGE_UNIT);
        check(rise[2] - rise[1] == STAGE_UNIT, "R12 zero code B to C",
              rise[2] - rise[1], STAGE_UNIT);
        check(rise[3] - rise[2] == STAGE_UNIT, "R12 zero code C to D",
              rise[3] - rise[2], STAGE_UNIT);
    endtask

    // R2, R6: dropping the power-on-reset signal clears the enables
    task automatic t_por_drop();
        por_done = 1'b0;
        @(negedge clk);
        check(pg_hi == 4'h0 && rdy_hi == 1'b0, "R2 por drop dark", pg_hi, 0);
    endtask

    task automatic finish_run();
        check(order_err == 0, "R1 order never violated", order_err, 0);
        check(pol_err == 0, "R10 polarity mirror", pol_err, 0);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        clear_rises();
        t_reset();
        t_nominal();
        t_ov_fault();
        t_uv_fault();
        t_zero_codes();
        t_por_drop();
        finish_run();
    end

    initial begin
        #1_800_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule